// File: doc/BRIEF.md
# BCD Calendar Clock Register Block

This block keeps wall-clock time and a calendar in packed BCD and exposes them through eight byte-wide registers on a simple synchronous bus. A one-cycle pulse on the tick input advances the time by one second. From that second the carry runs on to minutes, hours, the weekday, the day of the month, the month and the year. Month lengths and the four-year leap rule are handled in hardware.

A control byte holds three bits. The hold bit lets software load a new time as a single action. The freeze bit gives software a stable copy of the time to read over several bytes. The third bit is a calibration direction flag, which is only stored. Three more flags sit in spare bits of the time bytes: stop, kick-start and frequency-test. The bus takes one access per cycle with no back-pressure. Read data is combinational from the selected register, and a write takes effect at the next clock edge.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the registers read control 0x00, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00.
- R2: Addresses 0..7 select control, seconds, minutes, hours, weekday, day, month, year. The BCD field masks are 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x1F, 0xFF, and a written byte is cut to its mask, so bits above the mask read as zero (except the flags in R7, R8).
- R3: A tick pulse raises seconds by one in BCD (09 becomes 10). 59 seconds carries into minutes, 59 minutes into hours, and 23 hours into the day.
- R4: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R5: In February the day wraps after 29 when the year value is divisible by 4 (year 00 included), and after 28 otherwise.
- R6: Month 12 wraps to 01 and raises the year. The year counts 98 to 99 and wraps 99 to 00.
- R7: Seconds bit 7 is a stop flag. It can be written at any time, and while it is set tick pulses do not advance the time.
- R8: Hours bit 7 (kick-start) and weekday bit 6 (frequency test) can be written at any time and read back, and they leave the BCD fields in those bytes unchanged.
- R9: Control bit 6 (freeze) holds the visible time fixed while the internal count keeps running. Once it is cleared, reads show the running count, with every tick taken while frozen.
- R10: Control bit 7 (hold) accepts time writes into the visible copy, which ticks do not overwrite. Clearing it loads that copy into the counters, and a tick in the same cycle advances the loaded value.
- R11: Time-field writes made while the hold bit is clear are ignored.
- R12: Control bit 5 (calibration sign) is stored and read back. Control bits 4..0 read as zero.
- R13: The weekday counts 1 to 7 and wraps from 7 to 1 at midnight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Read data of the selected register |

## Verification
The assertions assume that software writes only legal BCD values within each field's range, because the carry logic does not check for invalid BCD digits. The bench always loads a full legal time under the hold bit. Where it writes stray upper bits to test masking, the value left after masking is still in range. The load and snapshot properties also assume that tick pulses last one cycle, and the bench drives ticks that way.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic [REG_W-1:0] sec;
    logic [REG_W-1:0] mins;
    logic [REG_W-1:0] hrs;
    logic [REG_W-1:0] wday;
    logic [REG_W-1:0] mday;
    logic [REG_W-1:0] mon;
    logic [REG_W-1:0] yr;
  } cal_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0, A_SEC = 3'd1, A_MIN = 3'd2, A_HOUR = 3'd3,
    A_WDAY = 3'd4, A_MDAY = 3'd5, A_MON = 3'd6, A_YEAR = 3'd7
  } reg_sel_e;

  localparam logic [REG_W-1:0] M_SEC  = 8'h7F;
  localparam logic [REG_W-1:0] M_MIN  = 8'h7F;
  localparam logic [REG_W-1:0] M_HOUR = 8'h3F;
  localparam logic [REG_W-1:0] M_WDAY = 8'h07;
  localparam logic [REG_W-1:0] M_MDAY = 8'h3F;
  localparam logic [REG_W-1:0] M_MON  = 8'h1F;
  localparam logic [REG_W-1:0] M_YEAR = 8'hFF;

  localparam cal_t CAL_RESET = '{sec: 8'h00, mins: 8'h00, hrs: 8'h00,
                                 wday: 8'h01, mday: 8'h01, mon: 8'h01, yr: 8'h00};

  function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year mod 4 from BCD: (10*tens + units) mod 4 == (2*tens + units) mod 4
  function automatic logic is_leap(input logic [REG_W-1:0] y);
    logic [1:0] r;
    r = y[1:0] + {y[4], 1'b0};
    return (r == 2'd0);
  endfunction

  function automatic logic [REG_W-1:0] month_last(input logic [REG_W-1:0] m,
                                                  input logic [REG_W-1:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_step.sv
module rtc_step
  import rtc_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  always_comb begin
    nxt = cur;
    if (cur.sec != 8'h59) nxt.sec = bcd_inc(cur.sec);
    else begin
      nxt.sec = 8'h00;
      if (cur.mins != 8'h59) nxt.mins = bcd_inc(cur.mins);
      else begin
        nxt.mins = 8'h00;
        if (cur.hrs != 8'h23) nxt.hrs = bcd_inc(cur.hrs);
        else begin
          nxt.hrs  = 8'h00;
          nxt.wday = (cur.wday == 8'h07) ? 8'h01 : bcd_inc(cur.wday);
          if (cur.mday != month_last(cur.mon, cur.yr)) nxt.mday = bcd_inc(cur.mday);
          else begin
            nxt.mday = 8'h01;
            if (cur.mon != 8'h12) nxt.mon = bcd_inc(cur.mon);
            else begin
              nxt.mon = 8'h01;
              nxt.yr  = (cur.yr == 8'h99) ? 8'h00 : bcd_inc(cur.yr);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic halt,
  input  logic load,
  input  cal_t load_val,
  output cal_t cnt
);
  cal_t base, stepped;

  assign base = load ? load_val : cnt;

  rtc_step u_step (.cur(base), .nxt(stepped));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= CAL_RESET;
    else if (tick && !halt)  cnt <= stepped;
    else                     cnt <= base;
  end
endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o
);
  logic wr_q, rd_q, sign_q, stop_q, kick_q, ftest_q;
  logic frozen, load;
  cal_t cnt_q, snap_q, view;
  reg_sel_e sel;

  assign sel    = reg_sel_e'(addr_i);
  assign frozen = wr_q | rd_q;
  assign load   = we_i && (sel == A_CTRL) && wr_q && !wdata_i[7];

  rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .halt(stop_q),
    .load(load), .load_val(snap_q), .cnt(cnt_q)
  );

  // control bits and flag bits: writable at any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {wr_q, rd_q, sign_q, stop_q, kick_q, ftest_q} <= '0;
    end else if (we_i) begin
      case (sel)
        A_CTRL: {wr_q, rd_q, sign_q} <= wdata_i[7:5];
        A_SEC:  stop_q  <= wdata_i[7];
        A_HOUR: kick_q  <= wdata_i[7];
        A_WDAY: ftest_q <= wdata_i[6];
        default: ;
      endcase
    end
  end

  // visible copy: follows the count unless frozen; takes writes under hold
  always_ff @(posedge clk) begin
    if (!rst_n) snap_q <= CAL_RESET;
    else if (!frozen) snap_q <= cnt_q;
    else if (we_i && wr_q) begin
      case (sel)
        A_SEC:  snap_q.sec  <= wdata_i & M_SEC;
        A_MIN:  snap_q.mins <= wdata_i & M_MIN;
        A_HOUR: snap_q.hrs  <= wdata_i & M_HOUR;
        A_WDAY: snap_q.wday <= wdata_i & M_WDAY;
        A_MDAY: snap_q.mday <= wdata_i & M_MDAY;
        A_MON:  snap_q.mon  <= wdata_i & M_MON;
        A_YEAR: snap_q.yr   <= wdata_i & M_YEAR;
        default: ;
      endcase
    end
  end

  assign view = frozen ? snap_q : cnt_q;

  always_comb begin
    case (sel)
      A_CTRL:  rdata_o = {wr_q, rd_q, sign_q, 5'd0};
      A_SEC:   rdata_o = {stop_q, view.sec[6:0]};
      A_MIN:   rdata_o = view.mins & M_MIN;
      A_HOUR:  rdata_o = {kick_q, 1'b0, view.hrs[5:0]};
      A_WDAY:  rdata_o = {1'b0, ftest_q, 3'd0, view.wday[2:0]};
      A_MDAY:  rdata_o = view.mday & M_MDAY;
      A_MON:   rdata_o = view.mon & M_MON;
      default: rdata_o = view.yr;
    endcase
  end
endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk
  import rtc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic we_i,
  input logic load,
  input logic stop_q,
  input logic rd_q,
  input logic wr_q,
  input cal_t cnt_q,
  input cal_t snap_q
);
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q.sec <= 8'h59 && cnt_q.mins <= 8'h59 && cnt_q.hrs <= 8'h23 &&
     cnt_q.mon >= 8'h01 && cnt_q.mon <= 8'h12 && cnt_q.mday >= 8'h01)); // R3

  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q.wday >= 8'h01 && cnt_q.wday <= 8'h07)); // R13

  AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !stop_q && !load) |=> (cnt_q != $past(cnt_q))); // R3

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !load) |=> $stable(cnt_q)); // R7

  AST_FREEZE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !wr_q) |=> $stable(snap_q)); // R9

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !we_i) |=> $stable(snap_q)); // R10

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !tick_i) |=> (cnt_q == $past(snap_q))); // R10
endmodule

bind bcd_rtc_regs rtc_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .we_i(we_i), .load(load),
  .stop_q(stop_q), .rd_q(rd_q), .wr_q(wr_q), .cnt_q(cnt_q), .snap_q(snap_q)
);

// File: tb/bcd_rtc_regs_tb.sv
module bcd_rtc_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic we_i = 1'b0;
  logic [7:0] rdata_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [2:0] adr_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  bcd_rtc_regs u_dut (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
                      .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o));

  // monitor: compares one queued item per cycle, just before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        logic [2:0] a;
        string t;
        e = exp_q.pop_front();
        a = adr_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata_o !== e) begin
          fails++;
          $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, a, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr_i = a;
    exp_q.push_back(e);
    adr_q.push_back(a);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1; tick_i = tk;
    @(negedge clk);
    we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic settime(input logic [7:0] s, mi, h, wd, d, mo, y);
    wr(3'd0, 8'h80);
    wr(3'd1, s); wr(3'd2, mi); wr(3'd3, h); wr(3'd4, wd);
    wr(3'd5, d); wr(3'd6, mo); wr(3'd7, y);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset contents
    chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1"); chk(3, 8'h00, "R1");
    chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1"); chk(6, 8'h01, "R1"); chk(7, 8'h00, "R1");
    // R12 sign bit
    wr(0, 8'h3F); chk(0, 8'h20, "R12");
    wr(0, 8'h00); chk(0, 8'h00, "R12");
    // R3 units carry
    settime(8'h08, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h24);
    tick(); chk(1, 8'h09, "R3");
    tick(); chk(1, 8'h10, "R3"); chk(2, 8'h34, "R3");
    // R3 R13 R6 full cascade
    settime(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick();
    chk(1, 8'h00, "R3"); chk(2, 8'h00, "R3"); chk(3, 8'h00, "R3");
    chk(4, 8'h01, "R13"); chk(5, 8'h01, "R6"); chk(6, 8'h01, "R6"); chk(7, 8'h00, "R6");
    settime(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h98);
    tick(); chk(7, 8'h99, "R6"); chk(4, 8'h03, "R13");
    // R4 month lengths
    settime(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24);
    tick(); chk(5, 8'h01, "R4"); chk(6, 8'h05, "R4");
    settime(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h24);
    tick(); chk(5, 8'h31, "R4"); chk(6, 8'h01, "R4");
    // R5 February
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick(); chk(5, 8'h29, "R5"); chk(6, 8'h02, "R5");
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    tick(); chk(5, 8'h01, "R5"); chk(6, 8'h03, "R5");
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    tick(); chk(5, 8'h01, "R5"); chk(6, 8'h03, "R5");
    settime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    tick(); chk(5, 8'h29, "R5");
    // R7 stop flag
    settime(8'h05, 8'h10, 8'h08, 8'h03, 8'h10, 8'h10, 8'h10);
    wr(1, 8'h80); chk(1, 8'h85, "R7");
    tick(); chk(1, 8'h85, "R7");
    wr(1, 8'h00); chk(1, 8'h05, "R7");
    tick(); chk(1, 8'h06, "R7");
    // R8 side flags
    wr(3, 8'h80); chk(3, 8'h88, "R8");
    wr(4, 8'h40); chk(4, 8'h43, "R8"); chk(3, 8'h88, "R8");
    wr(3, 8'h00); wr(4, 8'h00); chk(3, 8'h08, "R8"); chk(4, 8'h03, "R8");
    // R11 writes without hold ignored
    wr(2, 8'h45); chk(2, 8'h10, "R11");
    wr(7, 8'h55); chk(7, 8'h10, "R11");
    // R9 freeze
    wr(0, 8'h40); tick(); tick();
    chk(1, 8'h06, "R9"); chk(0, 8'h40, "R9");
    wr(0, 8'h00); chk(1, 8'h08, "R9");
    // R10 hold and load, R2 masking
    wr(0, 8'h80); wr(1, 8'h30); tick();
    chk(1, 8'h30, "R10");
    wr(2, 8'hA5); chk(2, 8'h25, "R2");
    wr(5, 8'hC7); chk(5, 8'h07, "R2");
    wr(0, 8'h00, 1'b1);
    chk(1, 8'h31, "R10"); chk(2, 8'h25, "R10"); chk(5, 8'h07, "R10"); chk(0, 8'h00, "R10");
    tick(); chk(1, 8'h32, "R10");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule